// File: doc/BRIEF.md
# Serial Audio Transmit Engine

This block turns 32-bit words written over a simple register bus into a two-slot serial audio stream. Software sets the data width, frame length, slot justification, bit order and bit-clock divider through control registers. It then pushes samples into a transmit data register that feeds a small FIFO and sets the run bit. The engine divides its master clock down to a bit clock. On each bit it drives one data bit together with a frame-sync level, and it takes one FIFO word at the start of every slot.

A request line asks an external DMA engine for more data when the FIFO drains to a programmable level. A self-timed clear operation returns the serializer to the start of a frame and empties the FIFO. Software polls the clear bit to learn when the clear has finished. If the FIFO runs dry in the middle of a transfer, the engine sends zeros and records the event in a sticky flag.

Top module: `stx_engine`

## Requirements
- R1: After reset, register 0x00 reads 0x0000001F, 0x08 reads 0x0000003F, 0x0C reads 0, 0x1C reads 0 and 0x20 reads 0. The outputs sclk_o, sdo_o, fs_o and dma_req_o are all low.
- R2: A bus write to 0x24 pushes the 32-bit data into the FIFO. Register 0x0C bits [5:0] report the FIFO occupancy. A write while the FIFO holds FIFO_DEPTH words is dropped.
- R3: While 0x1C bit 0 is 1, sclk_o has a period of 2*(DIV+1) clock cycles, where DIV is 0x38 bits [7:0]. While that bit is 0, sclk_o stays low.
- R4: A frame lasts FRM+1 bit clocks, where FRM is 0x08 bits [7:0]. The frame is split into two slots of (FRM+1)/2 bits each. Each slot takes one FIFO word at its first bit. Bits are sent on the falling sclk_o edge and are valid at the rising edge.
- R5: Bits [10:9] of 0x00 select the slot layout. With 01, data starts at slot bit 0 and fs_o is high in slot 0 and low in slot 1. With 10, data ends at the last slot bit and fs_o follows the same pattern as 01. With 00 or 11, data starts at slot bit 1 and fs_o is low in slot 0 and high in slot 1.
- R6: Bit 11 of 0x00 set sends the valid bits least-significant first. Clear, it sends them most-significant first.
- R7: Bits [4:0] of 0x00 hold W-1. Only the W low bits of a word are sent, and every other bit position of the slot carries 0.
- R8: A slot that starts with an empty FIFO sends all zeros and sets the sticky flag at bit 16 of 0x0C.
- R9: dma_req_o is high exactly when 0x10 bit 8 is 1, 0x1C bit 0 is 1, and the FIFO occupancy is at or below 0x10 bits [4:0].
- R10: Bit 0 of 0x1C reads back the last value written to it.
- R11: Writing 1 to 0x20 bit 0 empties the FIFO, clears the bit-16 flag and returns the serializer to frame bit 0. Bit 0 of 0x20 then reads 1 for exactly 2*(DIV+1) cycles and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| sclk_o | output | 1 | Bit clock |
| sdo_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame sync |
| dma_req_o | output | 1 | Transmit DMA request |

## Verification
The bench builds the engine with its default parameters: 32-bit words, a 32-entry FIFO and 8-bit frame and divider fields. It programs short frames of 6 and 8 bit clocks so that every mode, both bit orders and widths 1 to 4 can be swept in full. That sweep includes widths that overflow a 3-bit slot and a right-justified offset that goes negative. Every sweep runs three frames from four words, so the third frame always exercises the underflow path. Separate runs with divider values 0, 2 and 255 cover the bit-clock period, the DMA watermark compare and the length of the clear operation.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    JM_NORMAL = 2'b00,
    JM_LEFT   = 2'b01,
    JM_RIGHT  = 2'b10,
    JM_RSVD   = 2'b11
  } just_e;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_FRM  = 8'h08;
  localparam logic [7:0] A_LVL  = 8'h0C;
  localparam logic [7:0] A_DMA  = 8'h10;
  localparam logic [7:0] A_RUN  = 8'h1C;
  localparam logic [7:0] A_CLR  = 8'h20;
  localparam logic [7:0] A_TXD  = 8'h24;
  localparam logic [7:0] A_DIV  = 8'h38;
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rp_q];
  assign level_o = level_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      level_q <= level_q + LW'(do_push) - LW'(do_pop);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
  import stx_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int WW = $clog2(DW),
  localparam int SW = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [CW-1:0] div_i,
  input  logic [CW-1:0] frame_m1_i,
  input  logic [WW-1:0] width_m1_i,
  input  just_e         mode_i,
  input  logic          lsb_i,
  input  logic [DW-1:0] head_i,
  input  logic          empty_i,
  output logic          pop_o,
  output logic          urun_o,
  output logic          sclk_o,
  output logic          sdo_o,
  output logic          fs_o
);
  logic [CW-1:0] cnt_q, idx_q;
  logic          sclk_q, primed_q, sdo_q, fs_q;
  logic [DW-1:0] word_q, cur_word;

  logic [CW:0]          half, idx_x, j;
  logic                 second, slot_start, tick, in_rng, bit_val, fs_val;
  logic signed [SW-1:0] half_s, wid_s, j_s, off_s, pos_s, bidx_s;

  assign half   = ({1'b0, frame_m1_i} + 1'b1) >> 1;
  assign idx_x  = {1'b0, idx_q};
  assign second = (idx_x >= half);
  assign j      = second ? idx_x - half : idx_x;
  assign slot_start = (idx_x == '0) || (idx_x == half);

  assign half_s = $signed({1'b0, half});
  assign j_s    = $signed({1'b0, j});
  assign wid_s  = $signed(SW'(width_m1_i)) + 1;

  always_comb begin
    unique case (mode_i)
      JM_LEFT:  off_s = '0;
      JM_RIGHT: off_s = half_s - wid_s;
      default:  off_s = 1;
    endcase
  end

  assign pos_s  = j_s - off_s;
  assign in_rng = (pos_s >= 0) && (pos_s < wid_s);
  assign bidx_s = lsb_i ? pos_s : (wid_s - 1 - pos_s);
  assign cur_word = slot_start ? (empty_i ? '0 : head_i) : word_q;

  always_comb begin
    bit_val = 1'b0;
    for (int k = 0; k < DW; k++)
      if (bidx_s == $signed(SW'(k))) bit_val = cur_word[k];
  end

  assign fs_val = (mode_i == JM_LEFT || mode_i == JM_RIGHT) ? !second : second;
  assign tick   = run_i && !clr_i && (!primed_q || (cnt_q == div_i && sclk_q));
  assign pop_o  = tick && slot_start && !empty_i;
  assign urun_o = tick && slot_start && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; idx_q <= '0; word_q <= '0;
      sclk_q <= 1'b0; primed_q <= 1'b0; sdo_q <= 1'b0; fs_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; idx_q <= '0; word_q <= '0;
      sclk_q <= 1'b0; primed_q <= 1'b0; sdo_q <= 1'b0; fs_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0; sclk_q <= 1'b0; primed_q <= 1'b0;
      sdo_q <= 1'b0; fs_q <= 1'b0;
    end else begin
      if (!primed_q) begin
        primed_q <= 1'b1;
        cnt_q    <= '0;
      end else if (cnt_q == div_i) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (tick) begin
        sdo_q  <= in_rng & bit_val;
        fs_q   <= fs_val;
        word_q <= cur_word;
        idx_q  <= (idx_q == frame_m1_i) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;
  assign fs_o   = fs_q;

  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sclk_o);

  // R4
  sdo_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> !sclk_o);
endmodule

// File: rtl/stx_regs.sv
module stx_regs
  import stx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CW    = 8,
  parameter int DEPTH = 32,
  localparam int WW   = $clog2(DW),
  localparam int MW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic [7:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic [LW-1:0] level_i,
  input  logic          urun_i,
  output logic [WW-1:0] width_m1_o,
  output just_e         mode_o,
  output logic          lsb_o,
  output logic [CW-1:0] frame_m1_o,
  output logic [CW-1:0] div_o,
  output logic [MW-1:0] wm_o,
  output logic          dma_en_o,
  output logic          run_o,
  output logic          clr_o,
  output logic          push_o,
  output logic          urun_flag_o
);
  logic [CW:0] clr_cnt_q, clr_last;
  logic        clr_q, urun_q;

  assign clr_last = {div_o, 1'b1};
  assign push_o   = bus_wr_i && (bus_addr_i == A_TXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_m1_o <= '1;
      mode_o     <= JM_NORMAL;
      lsb_o      <= 1'b0;
      frame_m1_o <= CW'(63);
      div_o      <= '0;
      wm_o       <= '0;
      dma_en_o   <= 1'b0;
      run_o      <= 1'b0;
      clr_q      <= 1'b0;
      clr_cnt_q  <= '0;
      urun_q     <= 1'b0;
    end else begin
      if (clr_q) begin
        if (clr_cnt_q == clr_last) clr_q <= 1'b0;
        else clr_cnt_q <= clr_cnt_q + 1'b1;
      end
      if (clr_q) urun_q <= 1'b0;
      else if (urun_i) urun_q <= 1'b1;
      if (bus_wr_i) begin
        unique case (bus_addr_i)
          A_CTRL: begin
            width_m1_o <= bus_wdata_i[WW-1:0];
            mode_o     <= just_e'(bus_wdata_i[10:9]);
            lsb_o      <= bus_wdata_i[11];
          end
          A_FRM: frame_m1_o <= bus_wdata_i[CW-1:0];
          A_DIV: div_o      <= bus_wdata_i[CW-1:0];
          A_DMA: begin
            wm_o     <= bus_wdata_i[MW-1:0];
            dma_en_o <= bus_wdata_i[8];
          end
          A_RUN: run_o <= bus_wdata_i[0];
          A_CLR: if (bus_wdata_i[0] && !clr_q) begin
            clr_q     <= 1'b1;
            clr_cnt_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[WW-1:0] = width_m1_o;
        bus_rdata_o[10:9]   = mode_o;
        bus_rdata_o[11]     = lsb_o;
      end
      A_FRM: bus_rdata_o[CW-1:0] = frame_m1_o;
      A_DIV: bus_rdata_o[CW-1:0] = div_o;
      A_LVL: begin
        bus_rdata_o[LW-1:0] = level_i;
        bus_rdata_o[16]     = urun_q;
      end
      A_DMA: begin
        bus_rdata_o[MW-1:0] = wm_o;
        bus_rdata_o[8]      = dma_en_o;
      end
      A_RUN: bus_rdata_o[0] = run_o;
      A_CLR: bus_rdata_o[0] = clr_q;
      default: ;
    endcase
  end

  assign clr_o       = clr_q;
  assign urun_flag_o = urun_q;

  // R11
  clr_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_q) |=> clr_q);
endmodule

// File: rtl/stx_engine.sv
module stx_engine
  import stx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 8,
  localparam int WW        = $clog2(DATA_W),
  localparam int MW        = $clog2(FIFO_DEPTH),
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              fs_o,
  output logic              dma_req_o
);
  logic [WW-1:0]     width_m1;
  just_e             mode;
  logic              lsb, dma_en, run, clr, push, pop, urun, urun_flag;
  logic              empty, full;
  logic [CNT_W-1:0]  frame_m1, div;
  logic [MW-1:0]     wm;
  logic [LW-1:0]     level;
  logic [DATA_W-1:0] head;

  stx_regs #(.DW(DATA_W), .CW(CNT_W), .DEPTH(FIFO_DEPTH)) u_regs (
    .clk_i, .rst_ni, .bus_wr_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .level_i(level), .urun_i(urun),
    .width_m1_o(width_m1), .mode_o(mode), .lsb_o(lsb),
    .frame_m1_o(frame_m1), .div_o(div), .wm_o(wm), .dma_en_o(dma_en),
    .run_o(run), .clr_o(clr), .push_o(push), .urun_flag_o(urun_flag)
  );

  stx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(clr), .push_i(push), .wdata_i(bus_wdata_i),
    .pop_i(pop), .rdata_o(head), .empty_o(empty), .full_o(full),
    .level_o(level)
  );

  stx_serializer #(.DW(DATA_W), .CW(CNT_W)) u_ser (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .div_i(div),
    .frame_m1_i(frame_m1), .width_m1_i(width_m1), .mode_i(mode),
    .lsb_i(lsb), .head_i(head), .empty_i(empty), .pop_o(pop),
    .urun_o(urun), .sclk_o, .sdo_o, .fs_o
  );

  assign dma_req_o = dma_en && run && (level <= {1'b0, wm});

  // R8
  urun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun |=> urun_flag);

  // R11
  clr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (level == '0));

  // R2
  full_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop && !clr) |=> full);
endmodule

// File: tb/stx_engine_bench.sv
`timescale 1ns/1ps
module stx_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        sclk_o, sdo_o, fs_o, dma_req_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  stx_engine u_stx_engine (
    .clk_i, .rst_ni, .bus_wr_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .sclk_o, .sdo_o, .fs_o, .dma_req_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    #1 bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic do_clear();
    logic [31:0] v;
    wr(8'h20, 32'h1);
    do begin
      @(posedge clk_i); #1;
      rd(8'h20, v);
    end while (v[0]);
  endtask

  task automatic sweep(input int flen, input int mode, input int lsb, input int w);
    logic [31:0] words [4];
    logic [31:0] v;
    int half;
    half = flen / 2;
    do_clear();
    wr(8'h00, 32'(w - 1) | 32'(mode << 9) | 32'(lsb << 11));
    wr(8'h08, 32'(flen - 1));
    wr(8'h38, 32'h0);
    for (int k = 0; k < 4; k++) begin
      words[k] = (32'h9E37_79B9 * 32'(flen * 97 + mode * 13 + lsb * 5 + w * 3 + k + 1))
                 ^ 32'h5A5A_0F0F;
      wr(8'h24, words[k]);
    end
    wr(8'h1C, 32'h1);
    for (int b = 0; b < 3 * flen; b++) begin
      int f, i, s, jj, off, p, widx;
      logic [31:0] wd;
      logic eb, ef;
      f = b / flen; i = b % flen;
      s = (i >= half) ? 1 : 0;
      jj = i - s * half;
      widx = 2 * f + s;
      wd = (widx < 4) ? words[widx] : 32'h0;
      off = (mode == 1) ? 0 : (mode == 2) ? half - w : 1;
      p = jj - off;
      eb = (p >= 0 && p < w) ? (lsb != 0 ? wd[p] : wd[w - 1 - p]) : 1'b0;
      ef = (mode == 1 || mode == 2) ? (s == 0) : (s == 1);
      @(posedge sclk_o); #1;
      chk(sdo_o == eb, "R5 R6 R7 R4 R8", $sformatf("sdo L%0d m%0d l%0d w%0d bit%0d", flen, mode, lsb, w, b),
          32'(sdo_o), 32'(eb));
      chk(fs_o == ef, "R5", $sformatf("fs L%0d m%0d bit%0d", flen, mode, b), 32'(fs_o), 32'(ef));
    end
    rd(8'h0C, v);
    chk(v[16] == 1'b1, "R8", "underflow flag", 32'(v[16]), 32'h1);
    wr(8'h1C, 32'h0);
    @(posedge clk_i); #1;
    chk(sclk_o == 1'b0, "R3", "sclk low when stopped", 32'(sclk_o), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    bit prev;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    rd(8'h00, v); chk(v == 32'h1F, "R1", "ctrl reset", v, 32'h1F);
    rd(8'h08, v); chk(v == 32'h3F, "R1", "frame reset", v, 32'h3F);
    rd(8'h0C, v); chk(v == 32'h0, "R1", "level reset", v, 32'h0);
    rd(8'h1C, v); chk(v == 32'h0, "R1", "run reset", v, 32'h0);
    rd(8'h20, v); chk(v == 32'h0, "R1", "clear reset", v, 32'h0);
    chk({sclk_o, sdo_o, fs_o, dma_req_o} == 4'b0, "R1", "outputs reset",
        32'({sclk_o, sdo_o, fs_o, dma_req_o}), 32'h0);

    // R2 fill past depth
    for (int k = 0; k < 33; k++) begin
      wr(8'h24, 32'(k));
      if (k == 4) begin
        rd(8'h0C, v); chk(v[5:0] == 6'd5, "R2", "level after 5", 32'(v[5:0]), 32'd5);
      end
    end
    rd(8'h0C, v); chk(v[5:0] == 6'd32, "R2", "level saturates", 32'(v[5:0]), 32'd32);

    // R11 clear timing with DIV=0: busy for 2 cycles
    wr(8'h20, 32'h1);
    rd(8'h20, v); chk(v[0] == 1'b1, "R11", "busy at start", 32'(v[0]), 32'h1);
    @(posedge clk_i); #1;
    rd(8'h20, v); chk(v[0] == 1'b1, "R11", "busy last cycle", 32'(v[0]), 32'h1);
    @(posedge clk_i); #1;
    rd(8'h20, v); chk(v[0] == 1'b0, "R11", "busy done", 32'(v[0]), 32'h0);
    rd(8'h0C, v); chk(v[5:0] == 6'd0, "R11", "fifo flushed", 32'(v[5:0]), 32'h0);

    // R11 clear timing with DIV=2: busy for 6 cycles
    wr(8'h38, 32'h2);
    wr(8'h20, 32'h1);
    repeat (5) @(posedge clk_i);
    #1 rd(8'h20, v); chk(v[0] == 1'b1, "R11", "busy 6th cycle", 32'(v[0]), 32'h1);
    @(posedge clk_i); #1;
    rd(8'h20, v); chk(v[0] == 1'b0, "R11", "busy done div2", 32'(v[0]), 32'h0);

    // R3 R10 bit clock period with DIV=2
    wr(8'h08, 32'h7);
    for (int k = 0; k < 4; k++) wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); chk(v[0] == 1'b1, "R10", "run readback 1", 32'(v[0]), 32'h1);
    @(posedge sclk_o); #1;
    for (int rep = 0; rep < 2; rep++) begin
      n = 0; prev = 1'b1;
      do begin
        @(posedge clk_i); #1;
        n++;
        if (sclk_o && !prev) break;
        prev = sclk_o;
      end while (n < 100);
      chk(n == 6, "R3", "sclk period div2", 32'(n), 32'd6);
    end
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); chk(v[0] == 1'b0, "R10", "run readback 0", 32'(v[0]), 32'h0);
    repeat (10) begin
      @(posedge clk_i); #1;
      chk(sclk_o == 1'b0, "R3", "sclk held low", 32'(sclk_o), 32'h0);
    end
    do_clear();

    // R9 DMA request with slow bit clock
    wr(8'h38, 32'hFF);
    wr(8'h10, 32'h102);
    for (int k = 0; k < 4; k++) wr(8'h24, 32'(k));
    #1 chk(dma_req_o == 1'b0, "R9", "no req when stopped", 32'(dma_req_o), 32'h0);
    wr(8'h1C, 32'h1);
    @(posedge clk_i); #1;
    rd(8'h0C, v); chk(v[5:0] == 6'd3, "R4", "first word taken", 32'(v[5:0]), 32'd3);
    chk(dma_req_o == 1'b0, "R9", "level above mark", 32'(dma_req_o), 32'h0);
    wr(8'h10, 32'h103);
    #1 chk(dma_req_o == 1'b1, "R9", "level at mark", 32'(dma_req_o), 32'h1);
    wr(8'h10, 32'h003);
    #1 chk(dma_req_o == 1'b0, "R9", "dma disabled", 32'(dma_req_o), 32'h0);
    wr(8'h10, 32'h000);
    wr(8'h1C, 32'h0);
    wr(8'h38, 32'h0);
    do_clear();

    // R4 R5 R6 R7 R8 exhaustive small sweep
    for (int fl = 6; fl <= 8; fl += 2)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          for (int w = 1; w <= 4; w++)
            sweep(fl, m, l, w);

    // R11 clear drops the sticky flag
    do_clear();
    rd(8'h0C, v); chk(v[16] == 1'b0, "R11", "flag cleared", 32'(v[16]), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule